// File: doc/BRIEF.md
# I2C/SMBus Target Front End with Bus Timeout

This block is the serial front end of a small memory or register device on a two-wire bus. It runs on a fast system clock and oversamples the clock line and the data line. Each line passes through a two-stage synchronizer and then a digital filter that removes short spikes. From the cleaned lines the block finds START, repeated START and STOP conditions. It also matches a 7-bit target address and moves bytes in both directions, most significant bit first, with an acknowledge bit after each byte.

Written bytes reach the back end as one-cycle pulses that carry the byte. For a read, the block pulses a load request and captures the back end's byte in that same cycle. The data line is driven open-drain: the block only ever pulls it low.

The upper three address bits are fixed. The lower four come from two four-level strap pins, which arrive here already decoded to two bits each. An optional timeout, selected by an enable input, returns the interface to idle when the bus is stuck.

Top module: `smb_target`

## Requirements
- R1: The target responds only to the address byte {1,0,1,A3,A2,A1,A0,dir}, where bit 7 is sent first. On a match it pulls SDA low during the following acknowledge slot. On a mismatch it never drives SDA, and `active` stays low until the next START.
- R2: `addr_lo` supplies A1:A0 and `addr_hi` supplies A3:A2. The strap codes are ground=00, supply=01, clock line=10 and data line=11. All sixteen combinations select distinct addresses.
- R3: With dir=0, each following byte is sampled on SCL rising edges, MSB first. After its eighth bit the byte appears on `rx_data` together with a one-cycle `rx_valid` pulse, and it is acknowledged.
- R4: With dir=1, after the address acknowledge the block pulses `tx_load` and captures `tx_data` in that cycle. It then presents the byte MSB first, and SDA changes only while SCL is low.
- R5: A master NACK (SDA high in the acknowledge slot of a read byte) ends the read. SDA stays released, no further `tx_load` occurs and `active` is low until the next START.
- R6: A repeated START (a START without a preceding STOP) restarts address matching, so the direction can change within one transfer.
- R7: A STOP returns the block to idle: `active` and `read_mode` go low and SDA is released. Whenever `active` is low, SDA is released.
- R8: A level on SCL or SDA that lasts fewer than `FILT_LEN` system clocks is ignored. A level that lasts `FILT_LEN` clocks or more is accepted.
- R9: With `tmo_en`=1, if SCL shows no edge for `TMO_CYC` clocks (with SCL low, or with SCL high and SDA low), the block acts as if a STOP had arrived. An idle bus (both lines high) never times out. With `tmo_en`=0 the timeout has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oversamples the bus) |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_lo | input | 2 | Decoded strap giving A1:A0 |
| addr_hi | input | 2 | Decoded strap giving A3:A2 |
| tmo_en | input | 1 | Enables the stuck-bus timeout |
| active | output | 1 | Addressed and in a data phase |
| read_mode | output | 1 | Current phase is a master read |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a written byte |
| rx_data | output | 8 | Last byte written by the master |
| tx_load | output | 1 | One-cycle pulse: `tx_data` is captured now |
| tx_data | input | 8 | Next byte to send to the master |

## Verification
An error in the bit counter or in the state register appears directly at the data line. The acknowledge lands in the wrong slot, or it is missing, within the nine SCL periods of the byte that is in progress. The error also shows as a wrong written byte or a byte that is read back shifted. A wrong filter or edge detector changes whether a spike opens a transfer, and the next address byte makes that visible through the acknowledge. A timeout that fires early or never shows up about `TMO_CYC` clocks into a stall: `active` either drops or stays high, and the following byte is either acknowledged or ignored.

// File: rtl/smb_target.sv
module smb_target #(
  parameter int FILT_LEN = 4,
  parameter int TMO_CYC  = 4000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_lo,
  input  logic [1:0] addr_hi,
  input  logic       tmo_en,
  output logic       active,
  output logic       read_mode,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       tx_load,
  input  logic [7:0] tx_data
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WR, S_RD} st_t;

  logic [1:0] s1, s2, flt_d;
  wire  [1:0] flt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt_d <= 2'b11;
    end else begin
      s1 <= {scl_i, sda_i}; s2 <= s1; flt_d <= flt;
    end

  for (genvar i = 0; i < 2; i++) begin : g_flt
    logic [FW-1:0] cnt;
    logic          q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0; q <= 1'b1;
      end else if (s2[i] != q) begin
        if (cnt == FW'(FILT_LEN - 1)) begin q <= s2[i]; cnt <= '0; end
        else cnt <= cnt + FW'(1);
      end else cnt <= '0;
    assign flt[i] = q;
  end

  wire scl_q = flt[1], sda_q = flt[0];
  wire scl_d = flt_d[1], sda_d = flt_d[0];
  wire scl_rise = scl_q & ~scl_d;
  wire scl_fall = ~scl_q & scl_d;
  wire start_c  = scl_q & scl_d & sda_d & ~sda_q;
  wire stop_c   = scl_q & scl_d & ~sda_d & sda_q;

  logic [TW-1:0] tcnt;
  wire tmo_hit = (tcnt == TW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else if (!tmo_en || scl_rise || scl_fall || (scl_q && sda_q) || tmo_hit) tcnt <= '0;
    else tcnt <= tcnt + TW'(1);

  st_t        st;
  logic [3:0] bitn;
  logic [6:0] sh, txsh;
  logic       aack;
  wire  [7:0] byte_in = {sh, sda_q};
  wire  [6:0] own     = {3'b101, addr_hi, addr_lo};
  wire  [3:0] nxt     = (bitn == 4'd8) ? 4'd0 : bitn + 4'd1;

  assign active    = (st == S_WR) || (st == S_RD);
  assign read_mode = (st == S_RD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitn <= 4'hF; sh <= '0; txsh <= '0; aack <= 1'b0;
      sda_oe <= 1'b0; rx_valid <= 1'b0; rx_data <= '0; tx_load <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (stop_c || tmo_hit) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR; bitn <= 4'hF; sda_oe <= 1'b0; aack <= 1'b0;
      end else if (st != S_IDLE && scl_rise) begin
        if (bitn < 4'd8 && st != S_RD) sh <= byte_in[6:0];
        if (bitn == 4'd7 && st == S_ADDR) begin
          if (byte_in[7:1] == own) begin
            st <= byte_in[0] ? S_RD : S_WR; aack <= 1'b1;
          end else st <= S_IDLE;
        end
        if (bitn == 4'd7 && st == S_WR) begin
          rx_valid <= 1'b1; rx_data <= byte_in;
        end
        if (bitn == 4'd8 && st == S_RD && !aack && sda_q) st <= S_IDLE;
      end else if (st != S_IDLE && scl_fall) begin
        bitn <= nxt;
        if (nxt == 4'd0) aack <= 1'b0;
        case (st)
          S_WR: sda_oe <= (nxt == 4'd8);
          S_RD:
            if (nxt == 4'd8) sda_oe <= aack;
            else if (nxt == 4'd0) begin
              tx_load <= 1'b1; sda_oe <= ~tx_data[7]; txsh <= tx_data[6:0];
            end else begin
              sda_oe <= ~txsh[6]; txsh <= {txsh[5:0], 1'b0};
            end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic sda_oe,
  input logic active,
  input logic read_mode,
  input logic rx_valid,
  input logic tx_load
);
  a_r7_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sda_oe);
  a_r4_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);
  a_r3_rx_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (active && !read_mode));
  a_r3_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r4_load_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> read_mode);
  a_r4_load_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);
endmodule

bind smb_target smb_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe), .active(active),
  .read_mode(read_mode), .rx_valid(rx_valid), .tx_load(tx_load));

// File: tb/tb_smb_target.sv
module tb_smb_target;
  localparam int Q   = 20;
  localparam int FL  = 3;
  localparam int TMO = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, tmo_en = 1'b0;
  logic [1:0] addr_lo = 2'd0, addr_hi = 2'd0;
  logic sda_oe, active, read_mode, rx_valid, tx_load;
  logic [7:0] rx_data, tx_data;
  wire sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  logic [7:0] rx_log [16];
  int rx_n = 0, tx_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smb_target #(.FILT_LEN(FL), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .tmo_en(tmo_en), .active(active),
    .read_mode(read_mode), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_load(tx_load), .tx_data(tx_data));

  function automatic logic [7:0] txv(input int n);
    return 8'h5A + 8'(n) * 8'h27;
  endfunction
  assign tx_data = txv(tx_n);

  always @(posedge clk) begin
    if (rx_valid) begin rx_log[rx_n[3:0]] <= rx_data; rx_n <= rx_n + 1; end
    if (tx_load) tx_n <= tx_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic clk_bit(input logic drv, output logic smp);
    sda_m = drv; waitq();
    scl_m = 1'b1; waitq();
    smp = sda_line; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic start_c();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~mack, s);
  endtask

  function automatic logic [7:0] abyte(input logic [1:0] hi, input logic [1:0] lo, input logic rw);
    return {3'b101, hi, lo, rw};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int base, rk, tb;
    repeat (5) @(posedge clk);
    #1;
    chk(sda_oe == 1'b0, "R7 reset oe", sda_oe, 0);
    chk(active == 1'b0, "R7 reset active", active, 0);
    chk(rx_valid == 1'b0 && tx_load == 1'b0, "R3 reset pulses", rx_valid, 0);
    rst_n = 1'b1;
    waitq();

    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++) begin
        addr_hi = 2'(h); addr_lo = 2'(l);
        start_c(); wbyte(abyte(2'(h), 2'(l), 1'b0), ack);
        chk(ack == 1'b1, "R2 match ack", ack, 1);
        chk(active == 1'b1, "R1 active on match", active, 1);
        stop_c();
        start_c(); wbyte(abyte(2'(h), 2'(l) ^ 2'd1, 1'b0), ack);
        chk(ack == 1'b0 && active == 1'b0, "R2 neighbour ignored", ack, 0);
        stop_c();
        start_c(); wbyte({3'b100, 2'(h), 2'(l), 1'b0}, ack);
        chk(ack == 1'b0 && active == 1'b0, "R1 prefix mismatch", ack, 0);
        stop_c();
      end

    addr_hi = 2'd2; addr_lo = 2'd1;
    base = rx_n;
    start_c(); wbyte(abyte(2'd2, 2'd1, 1'b0), ack);
    chk(read_mode == 1'b0, "R3 write mode", read_mode, 0);
    for (int k = 0; k < 3; k++) begin
      wbyte(8'hC3 ^ 8'(k * 37), ack);
      chk(ack == 1'b1, "R3 data ack", ack, 1);
    end
    stop_c();
    chk(rx_n - base == 3, "R3 byte count", rx_n - base, 3);
    for (int k = 0; k < 3; k++)
      chk(rx_log[(base + k) % 16] == (8'hC3 ^ 8'(k * 37)), "R3 data value",
          rx_log[(base + k) % 16], 8'hC3 ^ 8'(k * 37));
    chk(active == 1'b0 && sda_oe == 1'b0, "R7 stop idles", active, 0);

    rk = tx_n;
    start_c(); wbyte(abyte(2'd2, 2'd1, 1'b1), ack);
    chk(ack == 1'b1 && read_mode == 1'b1, "R4 read select", read_mode, 1);
    for (int k = 0; k < 3; k++) begin
      rbyte(k != 2, d);
      chk(d == txv(rk + k), "R4 read data", d, txv(rk + k));
    end
    chk(active == 1'b0 && sda_oe == 1'b0, "R5 nack releases", active, 0);
    tb = tx_n;
    rbyte(1'b1, d);
    chk(d == 8'hFF, "R5 no drive after nack", d, 8'hFF);
    chk(tx_n == tb, "R5 no load after nack", tx_n, tb);
    stop_c();

    base = rx_n;
    start_c(); wbyte(abyte(2'd2, 2'd1, 1'b0), ack);
    wbyte(8'h42, ack);
    rk = tx_n;
    start_c(); wbyte(abyte(2'd2, 2'd1, 1'b1), ack);
    chk(ack == 1'b1 && read_mode == 1'b1, "R6 restart to read", read_mode, 1);
    rbyte(1'b0, d);
    chk(d == txv(rk), "R6 read after restart", d, txv(rk));
    stop_c();
    chk(rx_log[base % 16] == 8'h42, "R6 write before restart", rx_log[base % 16], 8'h42);

    @(posedge clk); #1 sda_m = 1'b0;
    repeat (FL - 1) @(posedge clk);
    #1 sda_m = 1'b1;
    waitq(); scl_m = 1'b0; waitq();
    wbyte(abyte(2'd2, 2'd1, 1'b0), ack);
    chk(ack == 1'b0 && active == 1'b0, "R8 short spike ignored", ack, 0);
    stop_c();
    @(posedge clk); #1 sda_m = 1'b0;
    repeat (FL + 1) @(posedge clk);
    #1 scl_m = 1'b0; waitq();
    wbyte(abyte(2'd2, 2'd1, 1'b0), ack);
    chk(ack == 1'b1, "R8 long level accepted", ack, 1);
    stop_c();

    tmo_en = 1'b1;
    start_c(); wbyte(abyte(2'd2, 2'd1, 1'b0), ack);
    chk(active == 1'b1, "R9 selected before stall", active, 1);
    repeat (TMO + 100) @(posedge clk);
    #1;
    chk(active == 1'b0, "R9 timeout scl low", active, 0);
    base = rx_n;
    wbyte(8'h99, ack);
    chk(ack == 1'b0 && rx_n == base, "R9 ignored after timeout", ack, 0);
    stop_c();

    start_c(); wbyte(abyte(2'd2, 2'd1, 1'b0), ack);
    sda_m = 1'b0; waitq(); scl_m = 1'b1;
    repeat (TMO + 100) @(posedge clk);
    #1;
    chk(active == 1'b0, "R9 timeout sda low", active, 0);
    sda_m = 1'b1;
    repeat (TMO + 100) @(posedge clk);
    #1;
    start_c(); wbyte(abyte(2'd2, 2'd1, 1'b0), ack);
    chk(ack == 1'b1, "R9 idle bus no timeout", ack, 1);
    stop_c();

    tmo_en = 1'b0;
    start_c(); wbyte(abyte(2'd2, 2'd1, 1'b0), ack);
    repeat (TMO + 100) @(posedge clk);
    #1;
    chk(active == 1'b1, "R9 disabled keeps state", active, 1);
    base = rx_n;
    wbyte(8'h17, ack);
    chk(ack == 1'b1 && rx_n == base + 1, "R9 disabled accepts byte", rx_n - base, 1);
    stop_c();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule